// File: doc/BRIEF.md
# Pipeline Hazard Detection and Forwarding

This block is the hazard control logic for a five-stage in-order integer pipeline. It compares the source register numbers of the instructions in the decode and execute stages with the destination register numbers held further down the pipe. From those comparisons it produces operand bypass selects and a load-use stall. The register file, ALU, memories and branch resolution sit outside. Only register numbers, write enables and load/store flags come in. Only multiplexer selects and pipeline hold/clear controls go out.

Both ALU operands in execute take a bypass select. A conditional branch compare uses the same operands, so a branch sees forwarded values with no stall. The store-data operand has a path of its own. In execute it picks from the memory-stage or writeback-stage result. In the memory stage it can still take the writeback value. A load followed at once by a consumer of its result stalls for one cycle: the PC and the fetch/decode register hold, and a bubble enters the decode/execute register. After that, forwarding supplies the loaded value. No other dependence ever stalls. A flush from branch resolution wins over a stall and clears the fetch/decode and decode/execute registers.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Each bypass select uses the encoding 2'b00 = register file, 2'b01 = writeback-stage value, 2'b10 = memory-stage (ALU) value. After reset, with all inputs zero, every select is 2'b00 and no hold, bubble or flush control is active.
- R2: An ALU operand source register that equals the memory-stage destination selects 2'b10. This applies only when the memory stage writes and is not a load. A load in the memory stage is never a bypass source.
- R3: An ALU operand source register that equals the writeback destination selects 2'b01 when writeback writes, unless R2 applies. When both stages match, the memory-stage value (2'b10) wins.
- R4: Register 0, and any stage whose write enable is low, is never a bypass source. The select stays 2'b00.
- R5: The execute-stage store-data select follows the R2–R4 rules on the execute rt field while ex_store is high. It is 2'b00 while ex_store is low.
- R6: The memory-stage store-data bypass fwd_sd_mem is 1 exactly when mem_store is high, writeback writes, and wb_dst equals a nonzero mem_rt.
- R7: A load in execute (ex_load and ex_wen high) whose nonzero destination equals id_rs or id_rt raises pc_hold, ifid_hold and idex_bubble together.
- R8: A non-load producer in execute never raises pc_hold or ifid_hold, whatever its destination.
- R9: A stall lasts exactly one cycle. In the cycle after a stall, no stall is raised even if the load-use condition still holds.
- R10: While flush is high, ifid_flush and idex_bubble are 1 and pc_hold and ifid_hold are 0, even when a load-use condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| id_rs | input | REG_W | Decode-stage first source register |
| id_rt | input | REG_W | Decode-stage second source register |
| ex_rs | input | REG_W | Execute-stage first source register |
| ex_rt | input | REG_W | Execute-stage second source / store-data register |
| ex_dst | input | REG_W | Execute-stage destination register |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_store | input | 1 | Execute-stage instruction is a store |
| mem_rt | input | REG_W | Memory-stage store-data register |
| mem_dst | input | REG_W | Memory-stage destination register |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_store | input | 1 | Memory-stage instruction is a store |
| wb_dst | input | REG_W | Writeback-stage destination register |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| flush | input | 1 | Branch-resolution flush request |
| fwd_a | output | 2 | First ALU operand bypass select |
| fwd_b | output | 2 | Second ALU operand bypass select |
| fwd_sd | output | 2 | Execute-stage store-data bypass select |
| fwd_sd_mem | output | 1 | Memory-stage store data takes writeback value |
| pc_hold | output | 1 | Hold the PC |
| ifid_hold | output | 1 | Hold the fetch/decode register |
| idex_bubble | output | 1 | Zero the decode/execute control bits |
| ifid_flush | output | 1 | Clear the fetch/decode register |

## Verification
The checker checks several properties on every cycle. Memory-stage priority over writeback, and register 0 never being a source, hold for the first operand. The stall outputs always rise together. A stall never lasts two cycles running. A flush always suppresses holds, and an ALU producer never stalls. The exact select value for every combination of source, destination, enable and load flag can only be shown by the bench's exhaustive sweep over a 3-bit register space. The same goes for the store-data paths in both stages and the one-cycle stall alternation under a persisting load-use condition.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_EXM = 2'b10
  } src_sel_e;

  // Younger (memory-stage) result wins over writeback.
  function automatic src_sel_e pick_src(input logic hit_exm, input logic hit_wb);
    if (hit_exm)     return SRC_EXM;
    else if (hit_wb) return SRC_WB;
    else             return SRC_RF;
  endfunction
endpackage

// File: rtl/opnd_fwd.sv
module opnd_fwd #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             en,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic             mem_load,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wen,
  output logic [1:0]       sel
);
  import hzd_pkg::*;
  logic src_live, hit_exm, hit_wb;
  assign src_live = en && (src != '0);
  assign hit_exm  = src_live && mem_wen && !mem_load && (mem_dst == src);
  assign hit_wb   = src_live && wb_wen && (wb_dst == src);
  assign sel      = pick_src(hit_exm, hit_wb);
endmodule

// File: rtl/load_use_det.sv
module load_use_det #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wen,
  input  logic             ex_load,
  output logic             hit
);
  logic prod_live;
  assign prod_live = ex_load && ex_wen && (ex_dst != '0);
  assign hit = prod_live && ((ex_dst == id_rs) || (ex_dst == id_rt));
endmodule

// File: rtl/stall_seq.sv
module stall_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic flush,
  output logic issued,
  output logic pc_hold,
  output logic ifid_hold,
  output logic idex_bubble,
  output logic ifid_flush
);
  logic stall_q;
  assign issued      = raw && !stall_q && !flush;
  assign pc_hold     = issued;
  assign ifid_hold   = issued;
  assign idex_bubble = issued || flush;
  assign ifid_flush  = flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= issued;
  end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic [REG_W-1:0] ex_rs,
  input  logic [REG_W-1:0] ex_rt,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic             ex_store,
  input  logic [REG_W-1:0] mem_rt,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic             mem_load,
  input  logic             mem_store,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wen,
  input  logic             flush,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic [1:0]       fwd_sd,
  output logic             fwd_sd_mem,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             idex_bubble,
  output logic             ifid_flush
);
  localparam int N_OPND = 3;

  logic [REG_W-1:0] opnd_src [N_OPND];
  logic             opnd_en  [N_OPND];
  logic [1:0]       opnd_sel [N_OPND];

  assign opnd_src[0] = ex_rs;
  assign opnd_en[0]  = 1'b1;
  assign opnd_src[1] = ex_rt;
  assign opnd_en[1]  = 1'b1;
  assign opnd_src[2] = ex_rt;
  assign opnd_en[2]  = ex_store;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    opnd_fwd #(.REG_W(REG_W)) u_fwd (
      .src(opnd_src[g]), .en(opnd_en[g]),
      .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_load(mem_load),
      .wb_dst(wb_dst), .wb_wen(wb_wen), .sel(opnd_sel[g])
    );
  end

  assign fwd_a  = opnd_sel[0];
  assign fwd_b  = opnd_sel[1];
  assign fwd_sd = opnd_sel[2];

  // Store data already in the memory stage can still take the writeback value.
  logic sd_mem_hit;
  assign sd_mem_hit = mem_store && wb_wen && (mem_rt != '0) && (wb_dst == mem_rt);
  assign fwd_sd_mem = sd_mem_hit;

  logic load_use_raw;
  logic stall_issued;

  load_use_det #(.REG_W(REG_W)) u_lud (
    .id_rs(id_rs), .id_rt(id_rt), .ex_dst(ex_dst),
    .ex_wen(ex_wen), .ex_load(ex_load), .hit(load_use_raw)
  );

  stall_seq u_stall (
    .clk(clk), .rst_n(rst_n), .raw(load_use_raw), .flush(flush),
    .issued(stall_issued), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
    .idex_bubble(idex_bubble), .ifid_flush(ifid_flush)
  );
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] ex_rs,
  input logic [REG_W-1:0] mem_dst,
  input logic             mem_wen,
  input logic             mem_load,
  input logic [REG_W-1:0] mem_rt,
  input logic             ex_load,
  input logic             flush,
  input logic [1:0]       fwd_a,
  input logic             fwd_sd_mem,
  input logic             pc_hold,
  input logic             ifid_hold,
  input logic             idex_bubble,
  input logic             ifid_flush
);
  // R3
  exm_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen && !mem_load && (mem_dst != '0) && (mem_dst == ex_rs)) |-> (fwd_a == 2'b10));
  // R4
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs == '0) |-> (fwd_a == 2'b00));
  // R6
  sd_mem_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rt == '0) |-> !fwd_sd_mem);
  // R7
  stall_trio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold |-> (ifid_hold && idex_bubble));
  // R8
  alu_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_load |-> !pc_hold);
  // R9
  stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold |=> !pc_hold);
  // R10
  flush_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!pc_hold && !ifid_hold && idex_bubble && ifid_flush));
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ex_rs(ex_rs), .mem_dst(mem_dst),
  .mem_wen(mem_wen), .mem_load(mem_load), .mem_rt(mem_rt),
  .ex_load(ex_load), .flush(flush), .fwd_a(fwd_a), .fwd_sd_mem(fwd_sd_mem),
  .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
  .ifid_flush(ifid_flush)
);

// File: tb/tb_pipe_hazard_ctrl.sv
module tb_pipe_hazard_ctrl;
  localparam int W = 3;
  localparam int NR = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] id_rs = '0, id_rt = '0, ex_rs = '0, ex_rt = '0, ex_dst = '0;
  logic [W-1:0] mem_rt = '0, mem_dst = '0, wb_dst = '0;
  logic ex_wen = 0, ex_load = 0, ex_store = 0;
  logic mem_wen = 0, mem_load = 0, mem_store = 0, wb_wen = 0, flush = 0;
  logic [1:0] fwd_a, fwd_b, fwd_sd;
  logic fwd_sd_mem, pc_hold, ifid_hold, idex_bubble, ifid_flush;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  pipe_hazard_ctrl #(.REG_W(W)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_sel(int s, int md, int mw, int ml, int wd, int ww, int en);
    if (en == 0 || s == 0) return 0;
    if (mw == 1 && ml == 0 && md == s) return 2;
    if (ww == 1 && wd == s) return 1;
    return 0;
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #2;
    // R1 reset state
    chk("R1 fwd_a", fwd_a, 0);
    chk("R1 fwd_b", fwd_b, 0);
    chk("R1 fwd_sd", fwd_sd, 0);
    chk("R1 sd_mem", fwd_sd_mem, 0);
    chk("R1 stall", {pc_hold, ifid_hold, idex_bubble, ifid_flush}, 0);

    // R2 R3 R4 R5 R6 R8: exhaustive bypass sweep, no load in execute
    ex_store = 1; mem_store = 1; ex_wen = 1; ex_load = 0;
    for (int s = 0; s < NR; s++)
      for (int md = 0; md < NR; md++)
        for (int wd = 0; wd < NR; wd++)
          for (int f = 0; f < 8; f++) begin
            ex_rs = W'(s); ex_rt = W'(s); mem_rt = W'(s); id_rs = W'(s);
            ex_dst = W'(s); mem_dst = W'(md); wb_dst = W'(wd);
            mem_wen = f[0]; mem_load = f[1]; wb_wen = f[2];
            #1;
            chk("R2/R3/R4 fwd_a", fwd_a, ref_sel(s, md, f[0], f[1], wd, f[2], 1));
            chk("R2/R3/R4 fwd_b", fwd_b, ref_sel(s, md, f[0], f[1], wd, f[2], 1));
            chk("R5 fwd_sd", fwd_sd, ref_sel(s, md, f[0], f[1], wd, f[2], 1));
            chk("R6 fwd_sd_mem", fwd_sd_mem, (f[2] && s != 0 && wd == s) ? 1 : 0);
            chk("R8 no ALU stall", {pc_hold, ifid_hold}, 0);
          end

    // R5: store data select idle when not a store
    ex_store = 0; mem_store = 0;
    ex_rt = 3'd5; mem_dst = 3'd5; mem_wen = 1; mem_load = 0; mem_rt = 3'd5; wb_dst = 3'd5; wb_wen = 1;
    #1;
    chk("R5 fwd_sd non-store", fwd_sd, 0);
    chk("R2 fwd_b still live", fwd_b, 2);
    chk("R6 sd_mem non-store", fwd_sd_mem, 0);
    mem_wen = 0; wb_wen = 0;

    // R7: load-use sweep, one idle cycle between cases
    for (int d = 0; d < NR; d++)
      for (int a = 0; a < NR; a++)
        for (int b = 0; b < NR; b++)
          for (int w = 0; w < 2; w++) begin
            @(negedge clk);
            ex_load = 1; ex_wen = w[0]; ex_dst = W'(d); id_rs = W'(a); id_rt = W'(b);
            #2;
            begin
              int e;
              e = (w == 1 && d != 0 && (d == a || d == b)) ? 1 : 0;
              chk("R7 pc_hold", pc_hold, e);
              chk("R7 ifid_hold", ifid_hold, e);
              chk("R7 idex_bubble", idex_bubble, e);
            end
            @(negedge clk) ex_load = 0;
          end

    // R9: persisting load-use alternates stall / no stall
    @(negedge clk);
    ex_load = 1; ex_wen = 1; ex_dst = 3'd4; id_rs = 3'd4; id_rt = 3'd0;
    #2 chk("R9 first cycle stall", pc_hold, 1);
    @(negedge clk) #2 chk("R9 second cycle no stall", pc_hold, 0);
    chk("R9 second cycle no bubble", idex_bubble, 0);
    @(negedge clk) #2 chk("R9 third cycle stall again", pc_hold, 1);

    // R10: flush overrides a load-use stall
    @(negedge clk) ex_load = 0;
    @(negedge clk) ex_load = 1; flush = 1;
    #2;
    chk("R10 pc_hold", pc_hold, 0);
    chk("R10 ifid_hold", ifid_hold, 0);
    chk("R10 idex_bubble", idex_bubble, 1);
    chk("R10 ifid_flush", ifid_flush, 1);
    @(negedge clk) flush = 0;
    #2 chk("R10 stall after flush drops", pc_hold, 1);
    @(negedge clk) ex_load = 0;
    #2 chk("R1 idle after", {pc_hold, ifid_hold, idex_bubble, ifid_flush}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule